// File: doc/BRIEF.md
# IOMMU Context Register Bank

This block holds the per-context configuration and fault state of a small I/O address translation unit. It serves up to `NUM_CTX` translation contexts (at most 32, 8 by default). Each context owns a 64-byte group of registers: a control word, a translation-control word, a bus-control word, a two-word table base, two memory-attribute words, a fault status word and a captured fault address. Software reaches them over a simple 32-bit register bus with separate write and read strobes. Read data returns one cycle after the read strobe.

The table walker and the TLB arrays are outside this block. They are represented by a per-context `flush_done` pulse and by a fault-event port. The fault-event port names the context, the fault flags, an error code, an error level and the offending address. Each context runs two small state machines.

- **Flush machine.** States `FL_IDLE` and `FL_BUSY`.
  - `start_flush` (a control write with the flush bit set) moves it from `FL_IDLE` to `FL_BUSY`.
  - `flush_finish` moves it from `FL_BUSY` to `FL_IDLE`, on a done pulse or after `FLUSH_LIMIT` busy cycles.
- **Fault machine.** States `FT_EMPTY` and `FT_HELD`.
  - `fault_capture` moves it from `FT_EMPTY` to `FT_HELD`. It latches flags, code, level and address.
  - `status_clear` moves it from `FT_HELD` to `FT_EMPTY`. It is caused by a write of zero to the status word.

Each context drives an interrupt while its interrupt enable is set and a fault is held. These interrupts are ORed into one line.

A second copy of the whole register window can be opened at byte offset 0x800 through `alias_sel`.

Top module: `iommu_ctx_regbank`

## Requirements
- R1: After reset every register of every context reads 0, and `ctx_irq` and `irq` are 0.
- R2: Each context's registers are at these byte offsets:
  - control at 0x00. Writable bits are 0 (enable), 2 (interrupt enable), 3, 5:4, 16 and 17; all other bits read 0.
  - translation control at 0x08.
  - bus control at 0x0C.
  - table base low at 0x10 and table base high at 0x14.
  - attribute words at 0x28 and 0x2C.

  All registers except control are full 32-bit read/write. Read data appears with `bus_rvalid` in the cycle after `bus_rd`.
- R3: The context index is address bits 10:6, so groups repeat every 0x40 bytes. An index of `NUM_CTX` or above, or an offset not listed in R2, R6 or R8, reads 0 and ignores writes.
- R4: A control write with bit 1 set makes bit 1 read 1 until that context's `flush_done` pulse. Bit 1 reads 0 from the cycle after the pulse. A pulse on another context has no effect.
- R5: Without a done pulse, a flush ends by itself after `FLUSH_LIMIT` cycles (16 by default).
- R6: A fault event with no fault already held is captured into the status word at 0x20:
  - `flt_flags[0]` → bit 0 (translation), `flt_flags[1]` → bit 1 (page), `flt_flags[2]` → bit 2 (walk abort), `flt_flags[3]` → bit 4 (multiple hit).
  - `flt_code` → bits 10:8.
  - `flt_level` → bits 13:12.

  The fault address is captured into the word at 0x30.
- R7: While any fault flag is held, further fault events on that context are dropped. A fault event whose flags are all zero has no effect.
- R8: Writing zero to the status word clears the flags, code, level and the fault address, so both words read 0. A nonzero write to the status word is ignored. A clear and a fault in the same cycle leave the status word clear.
- R9: `ctx_irq[i]` is high while context i has interrupt enable set and a fault held. `irq` is the OR of `ctx_irq`.
- R10: With `alias_sel` high, addresses 0x800 and above reach the same registers as the address 0x800 lower. With `alias_sel` low, those addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alias_sel | input | 1 | Opens the second register window at 0x800 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| flt_valid | input | 1 | Fault event strobe |
| flt_ctx | input | CTX_W | Context the fault belongs to |
| flt_flags | input | 4 | Fault flags {multi-hit, abort, page, translation} |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Error level |
| flt_addr | input | 32 | Faulting address |
| flush_done | input | NUM_CTX | Per-context flush completion pulse |
| ctx_irq | output | NUM_CTX | Per-context interrupt |
| irq | output | 1 | OR of all context interrupts |

## Verification
Register writes, fault events and done pulses take effect at the first rising edge that samples them. Interrupts therefore change in that same cycle. Read data follows one edge after the read strobe. The bench drives every stimulus at a falling edge, enqueues each expected read value as the read strobe goes out, and lets a monitor compare at the falling edge where `bus_rvalid` is high. For the self-ending flush, the bench counts falling edges from the write so that one read falls inside the `FLUSH_LIMIT` window and one falls after it.

// File: rtl/iommu_rb_pkg.sv
package iommu_rb_pkg;
    localparam int ADDR_W = 12;
    localparam int OFF_W  = 6;
    localparam int SLOT_W = ADDR_W - 1 - OFF_W;

    localparam logic [OFF_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [OFF_W-1:0] OFS_XLAT  = 6'h08;
    localparam logic [OFF_W-1:0] OFS_BUS   = 6'h0C;
    localparam logic [OFF_W-1:0] OFS_BASLO = 6'h10;
    localparam logic [OFF_W-1:0] OFS_BASHI = 6'h14;
    localparam logic [OFF_W-1:0] OFS_STAT  = 6'h20;
    localparam logic [OFF_W-1:0] OFS_ATTR0 = 6'h28;
    localparam logic [OFF_W-1:0] OFS_ATTR1 = 6'h2C;
    localparam logic [OFF_W-1:0] OFS_FADDR = 6'h30;

    localparam logic [31:0] CTRL_WMASK = 32'h0003_003D;
    localparam int CTRL_FLUSH_BIT = 1;
    localparam int CTRL_IE_BIT    = 2;

    typedef enum logic [0:0] {FL_IDLE, FL_BUSY}  fl_state_e;
    typedef enum logic [0:0] {FT_EMPTY, FT_HELD} ft_state_e;
endpackage

// File: rtl/iommu_addr_decode.sv
module iommu_addr_decode
    import iommu_rb_pkg::*;
#(
    parameter int NUM_CTX = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              alias_sel,
    output logic [NUM_CTX-1:0] ctx_sel,
    output logic [OFF_W-1:0]  off
);
    logic [SLOT_W-1:0] slot;
    logic              window_ok;

    assign slot      = addr[ADDR_W-2:OFF_W];
    assign window_ok = !addr[ADDR_W-1] || alias_sel;
    assign off       = addr[OFF_W-1:0];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_sel
        assign ctx_sel[i] = window_ok && (slot == SLOT_W'(i));
    end
endmodule

// File: rtl/iommu_ctx_slice.sv
module iommu_ctx_slice
    import iommu_rb_pkg::*;
#(
    parameter int FLUSH_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] reg_off,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             flt_hit,
    input  logic [3:0]       flt_flags,
    input  logic [2:0]       flt_code,
    input  logic [1:0]       flt_level,
    input  logic [31:0]      flt_addr,
    input  logic             flush_done,
    output logic             irq_o
);
    localparam int CW = $clog2(FLUSH_LIMIT + 1);

    logic [31:0] ctrl_q, xlat_q, bus_q, baslo_q, bashi_q, attr0_q, attr1_q;
    logic [3:0]  flags_q;
    logic [2:0]  code_q;
    logic [1:0]  level_q;
    logic [31:0] ear_q;
    logic [31:0] status_word;

    fl_state_e   fl_q, fl_d;
    ft_state_e   ft_q, ft_d;
    logic [CW-1:0] fl_cnt;

    logic wr_ctrl, start_flush, clr_wr, flush_busy, fault_held;

    assign wr_ctrl     = wr_en && (reg_off == OFS_CTRL);
    assign start_flush = wr_ctrl && wr_data[CTRL_FLUSH_BIT];
    assign clr_wr      = wr_en && (reg_off == OFS_STAT) && (wr_data == 32'h0);
    assign flush_busy  = (fl_q == FL_BUSY);
    assign fault_held  = (ft_q == FT_HELD);

    // next-state logic for both machines
    always_comb begin
        fl_d = fl_q;
        unique case (fl_q)
            FL_IDLE: if (start_flush) fl_d = FL_BUSY;
            FL_BUSY: if (flush_done || fl_cnt == CW'(FLUSH_LIMIT - 1)) fl_d = FL_IDLE;
        endcase
        ft_d = ft_q;
        unique case (ft_q)
            FT_EMPTY: if (!clr_wr && flt_hit && (|flt_flags)) ft_d = FT_HELD;
            FT_HELD:  if (clr_wr) ft_d = FT_EMPTY;
        endcase
    end

    // state registers and their data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q    <= FL_IDLE;
            ft_q    <= FT_EMPTY;
            fl_cnt  <= '0;
            flags_q <= '0;
            code_q  <= '0;
            level_q <= '0;
            ear_q   <= '0;
        end else begin
            fl_q   <= fl_d;
            ft_q   <= ft_d;
            fl_cnt <= (fl_q == FL_BUSY) ? fl_cnt + CW'(1) : '0;
            if (ft_q == FT_EMPTY && ft_d == FT_HELD) begin
                flags_q <= flt_flags;
                code_q  <= flt_code;
                level_q <= flt_level;
                ear_q   <= flt_addr;
            end else if (clr_wr) begin
                flags_q <= '0;
                code_q  <= '0;
                level_q <= '0;
                ear_q   <= '0;
            end
        end
    end

    // plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            xlat_q  <= '0;
            bus_q   <= '0;
            baslo_q <= '0;
            bashi_q <= '0;
            attr0_q <= '0;
            attr1_q <= '0;
        end else if (wr_en) begin
            case (reg_off)
                OFS_CTRL:  ctrl_q  <= wr_data & CTRL_WMASK;
                OFS_XLAT:  xlat_q  <= wr_data;
                OFS_BUS:   bus_q   <= wr_data;
                OFS_BASLO: baslo_q <= wr_data;
                OFS_BASHI: bashi_q <= wr_data;
                OFS_ATTR0: attr0_q <= wr_data;
                OFS_ATTR1: attr1_q <= wr_data;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        status_word = {18'h0, level_q, 1'b0, code_q, 3'b0,
                       flags_q[3], 1'b0, flags_q[2:0]};
        irq_o = ctrl_q[CTRL_IE_BIT] && fault_held;
        case (reg_off)
            OFS_CTRL:  rd_data = ctrl_q | (32'(flush_busy) << CTRL_FLUSH_BIT);
            OFS_XLAT:  rd_data = xlat_q;
            OFS_BUS:   rd_data = bus_q;
            OFS_BASLO: rd_data = baslo_q;
            OFS_BASHI: rd_data = bashi_q;
            OFS_STAT:  rd_data = status_word;
            OFS_ATTR0: rd_data = attr0_q;
            OFS_ATTR1: rd_data = attr1_q;
            OFS_FADDR: rd_data = ear_q;
            default:   rd_data = 32'h0;
        endcase
    end
endmodule

// File: rtl/iommu_ctx_regbank.sv
module iommu_ctx_regbank
    import iommu_rb_pkg::*;
#(
    parameter int NUM_CTX     = 8,
    parameter int FLUSH_LIMIT = 16,
    localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alias_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic               flt_valid,
    input  logic [CTX_W-1:0]   flt_ctx,
    input  logic [3:0]         flt_flags,
    input  logic [2:0]         flt_code,
    input  logic [1:0]         flt_level,
    input  logic [31:0]        flt_addr,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic [NUM_CTX-1:0] ctx_irq,
    output logic               irq
);
    logic [NUM_CTX-1:0] ctx_sel;
    logic [OFF_W-1:0]   reg_off;
    logic [31:0]        slice_rd [NUM_CTX];
    logic [31:0]        rd_mux;

    iommu_addr_decode #(.NUM_CTX(NUM_CTX)) u_dec (
        .addr      (bus_addr),
        .alias_sel (alias_sel),
        .ctx_sel   (ctx_sel),
        .off       (reg_off)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        iommu_ctx_slice #(.FLUSH_LIMIT(FLUSH_LIMIT)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_wr && ctx_sel[i]),
            .reg_off    (reg_off),
            .wr_data    (bus_wdata),
            .rd_data    (slice_rd[i]),
            .flt_hit    (flt_valid && (flt_ctx == CTX_W'(i))),
            .flt_flags  (flt_flags),
            .flt_code   (flt_code),
            .flt_level  (flt_level),
            .flt_addr   (flt_addr),
            .flush_done (flush_done[i]),
            .irq_o      (ctx_irq[i])
        );
    end

    always_comb begin
        rd_mux = 32'h0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (ctx_sel[i]) rd_mux = rd_mux | slice_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= bus_rd ? rd_mux : 32'h0;
            bus_rvalid <= bus_rd;
        end
    end

    assign irq = |ctx_irq;
endmodule

// File: rtl/iommu_ctx_slice_chk.sv
module iommu_ctx_slice_chk #(
    parameter int FLUSH_LIMIT = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_busy,
    input logic        flush_done,
    input logic        fault_held,
    input logic        clr_wr,
    input logic        wr_ctrl,
    input logic        flt_hit,
    input logic [3:0]  flt_flags,
    input logic [31:0] flt_addr,
    input logic [31:0] status_word,
    input logic [31:0] ear_q,
    input logic        irq_o
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_run <= 0;
        else if (flush_busy) busy_run <= busy_run + 1;
        else                 busy_run <= 0;
    end

    a_r4_done_ends_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy && flush_done |=> !flush_busy);

    a_r5_flush_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= FLUSH_LIMIT);

    a_r6_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_held && flt_hit && (|flt_flags) && !clr_wr |=> ear_q == $past(flt_addr));

    a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        fault_held && !clr_wr |=> $stable(status_word) && $stable(ear_q));

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> status_word == 32'h0 && ear_q == 32'h0);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(flt_hit) || $past(wr_ctrl));
endmodule

bind iommu_ctx_slice iommu_ctx_slice_chk #(.FLUSH_LIMIT(FLUSH_LIMIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_busy  (flush_busy),
    .flush_done  (flush_done),
    .fault_held  (fault_held),
    .clr_wr      (clr_wr),
    .wr_ctrl     (wr_ctrl),
    .flt_hit     (flt_hit),
    .flt_flags   (flt_flags),
    .flt_addr    (flt_addr),
    .status_word (status_word),
    .ear_q       (ear_q),
    .irq_o       (irq_o)
);

// File: tb/iommu_ctx_regbank_test.sv
module iommu_ctx_regbank_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alias_sel = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_ctx = '0;
    logic [3:0]  flt_flags = '0;
    logic [2:0]  flt_code = '0;
    logic [1:0]  flt_level = '0;
    logic [31:0] flt_addr = '0;
    logic [7:0]  flush_done = '0;
    logic [7:0]  ctx_irq;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    iommu_ctx_regbank uut (
        .clk(clk), .rst_n(rst_n), .alias_sel(alias_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .flt_valid(flt_valid), .flt_ctx(flt_ctx), .flt_flags(flt_flags),
        .flt_code(flt_code), .flt_level(flt_level), .flt_addr(flt_addr),
        .flush_done(flush_done), .ctx_irq(ctx_irq), .irq(irq)
    );

    function automatic logic [31:0] stat_val(logic [3:0] f, logic [2:0] c, logic [1:0] l);
        return (32'(l) << 12) | (32'(c) << 8) | (32'(f[3]) << 4) | 32'(f[2:0]);
    endfunction

    // monitor: compares each returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic fault(input logic [2:0] c, input logic [3:0] f, input logic [2:0] code,
                         input logic [1:0] l, input logic [31:0] a);
        flt_valid = 1'b1; flt_ctx = c; flt_flags = f; flt_code = code;
        flt_level = l; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic pulse_done(input int c);
        flush_done[c] = 1'b1;
        @(negedge clk);
        flush_done = '0;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(32'(irq), 0, "R1 irq after reset");
        check(32'(ctx_irq), 0, "R1 ctx_irq after reset");
        rd(12'h000, 0, "R1 ctrl ctx0");
        rd(12'h160, 0, "R1 status ctx5");
        rd(12'h030, 0, "R1 fault address ctx0");

        // R2 register map and masks
        wr(12'h000, 32'hFFFF_FFFD);
        rd(12'h000, 32'h0003_003D, "R2 ctrl mask");
        wr(12'h008, 32'h8000_3510);
        wr(12'h00C, 32'h0000_0005);
        wr(12'h010, 32'hDEAD_B000);
        wr(12'h014, 32'h0000_00A5);
        wr(12'h028, 32'h0004_FF44);
        wr(12'h02C, 32'h1234_5678);
        rd(12'h008, 32'h8000_3510, "R2 translation control");
        rd(12'h00C, 32'h0000_0005, "R2 bus control");
        rd(12'h010, 32'hDEAD_B000, "R2 base low");
        rd(12'h014, 32'h0000_00A5, "R2 base high");
        rd(12'h028, 32'h0004_FF44, "R2 attr0");
        rd(12'h02C, 32'h1234_5678, "R2 attr1");

        // R3 stride, out-of-range context, unused offset
        wr(12'h1D0, 32'h7777_0000);
        rd(12'h1D0, 32'h7777_0000, "R3 ctx7 base low");
        rd(12'h010, 32'hDEAD_B000, "R3 ctx0 untouched by ctx7");
        wr(12'h210, 32'h0000_FFFF);
        rd(12'h210, 0, "R3 ctx8 reads zero");
        rd(12'h010, 32'hDEAD_B000, "R3 ctx0 untouched by ctx8 write");
        wr(12'h004, 32'h0000_00FF);
        rd(12'h004, 0, "R3 unused offset");

        // R4 flush ended by done pulse
        wr(12'h080, 32'h0000_0003);
        rd(12'h080, 32'h0000_0003, "R4 flush pending");
        pulse_done(2);
        rd(12'h080, 32'h0000_0001, "R4 flush cleared by done");
        wr(12'h080, 32'h0000_0003);
        pulse_done(3);
        rd(12'h080, 32'h0000_0003, "R4 other context done ignored");
        repeat (20) @(negedge clk);

        // R5 flush ended by cycle limit
        wr(12'h100, 32'h0000_0002);
        rd(12'h100, 32'h0000_0002, "R5 flush busy start");
        repeat (10) @(negedge clk);
        rd(12'h100, 32'h0000_0002, "R5 flush busy inside window");
        repeat (10) @(negedge clk);
        rd(12'h100, 32'h0000_0000, "R5 flush ended by limit");

        // R6 capture, R9 interrupt
        wr(12'h040, 32'h0000_0004);
        fault(3'd1, 4'b0101, 3'd4, 2'd2, 32'h1234_5678);
        check(32'(ctx_irq), 32'h02, "R9 ctx_irq after fault");
        check(32'(irq), 1, "R9 irq after fault");
        rd(12'h060, stat_val(4'b0101, 3'd4, 2'd2), "R6 status capture");
        rd(12'h070, 32'h1234_5678, "R6 address capture");

        // R7 later faults dropped, zero-flag event ignored
        fault(3'd1, 4'b1000, 3'd5, 2'd1, 32'hAAAA_0000);
        rd(12'h060, stat_val(4'b0101, 3'd4, 2'd2), "R7 status kept");
        rd(12'h070, 32'h1234_5678, "R7 address kept");
        fault(3'd6, 4'b0000, 3'd1, 2'd1, 32'h5555_0000);
        rd(12'h1A0, 0, "R7 zero-flag status");
        rd(12'h1B0, 0, "R7 zero-flag address");

        // R8 clear semantics
        wr(12'h060, 32'h0000_0001);
        rd(12'h060, stat_val(4'b0101, 3'd4, 2'd2), "R8 nonzero write ignored");
        wr(12'h060, 32'h0);
        rd(12'h060, 0, "R8 status cleared");
        rd(12'h070, 0, "R8 address cleared");
        check(32'(irq), 0, "R9 irq low after clear");
        bus_wr = 1'b1; bus_addr = 12'h060; bus_wdata = 32'h0;
        flt_valid = 1'b1; flt_ctx = 3'd1; flt_flags = 4'b0001; flt_code = 3'd1;
        flt_level = 2'd1; flt_addr = 32'h0BAD_0000;
        @(negedge clk);
        bus_wr = 1'b0; flt_valid = 1'b0;
        rd(12'h060, 0, "R8 clear wins over same-cycle fault");
        fault(3'd1, 4'b0010, 3'd1, 2'd3, 32'h0000_4000);
        rd(12'h060, stat_val(4'b0010, 3'd1, 2'd3), "R8 recapture after clear");
        rd(12'h070, 32'h0000_4000, "R8 recapture address");

        // R9 enable gating and OR
        fault(3'd6, 4'b0001, 3'd0, 2'd0, 32'h0000_0100);
        check(32'(ctx_irq), 32'h02, "R9 ctx6 masked");
        wr(12'h180, 32'h0000_0004);
        check(32'(ctx_irq), 32'h42, "R9 ctx6 enabled");
        wr(12'h060, 32'h0);
        check(32'(ctx_irq), 32'h40, "R9 ctx1 cleared");
        check(32'(irq), 1, "R9 irq from ctx6 alone");
        wr(12'h1A0, 32'h0);
        check(32'(irq), 0, "R9 irq all clear");

        // R10 alias window
        rd(12'h810, 0, "R10 alias closed read");
        wr(12'h810, 32'h0000_1111);
        rd(12'h010, 32'hDEAD_B000, "R10 alias closed write ignored");
        alias_sel = 1'b1;
        rd(12'h810, 32'hDEAD_B000, "R10 alias open read");
        wr(12'h80C, 32'h0000_0003);
        rd(12'h00C, 32'h0000_0003, "R10 alias open write");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule